// File: doc/BRIEF.md
# Synchronous Rectifier Soft-Start Duty Controller

This block sets the duty command for the two synchronous-rectifier (SR) gates of a digitally controlled bridge or push-pull converter. It runs a three-state sequencer: **IDLE_OFF**, **SOFT_RAMP** and **STEADY_COMP**. The block leaves IDLE_OFF one clock after enable is seen (transition *arm*). It leaves SOFT_RAMP for STEADY_COMP when the soft-start level code reaches a fixed threshold (transition *handover*). Any state returns to IDLE_OFF as soon as enable drops (transition *kill*).

In SOFT_RAMP the SR duty comes from the compensation code compared with an internal ramp of fixed peak. The result has a floor of one half and a ceiling of the complement of the primary duty. In secondary-side mode a fast signed pre-bias correction term can move it up or down. In STEADY_COMP the SR duty is the complement of the primary duty, and the correction term no longer has any effect. Duty values are DW-bit fractions of one half-period, so code 1023 is full scale. A new duty is taken only on a half-cycle boundary strobe.

Top module: `sr_duty_ctrl`

## Requirements
- R1: After reset `sr_duty` is 0, and `sr_on` and `ss_done` are 0.
- R2: When `en` is low at a clock edge, `sr_duty` becomes 0 and `sr_on` and `ss_done` become 0 after that edge, whether or not `hc_tick` is high.
- R3: The arm transition: with `en` high in IDLE_OFF, the next edge enters SOFT_RAMP and `sr_on` reads 1 after it. `sr_on` stays 1 until the kill transition.
- R4: While `en` is high, `sr_duty` changes only at an edge where `hc_tick` is 1. Changes to other inputs at other edges have no effect on it.
- R5: In SOFT_RAMP with `mode_sec`=0, the raw duty is floor(min(comp_code,768)*1024/768), saturated to 1023. 768 is the internal ramp peak, standing for 3.0 V at 256 codes per volt.
- R6: The soft-start duty is never below 512 (one half) unless the ceiling of R7 is lower.
- R7: The soft-start duty is never above 1023 − `pri_duty`. When this ceiling is below 512, the ceiling wins over the floor.
- R8: With `mode_sec`=1 in SOFT_RAMP, the signed correction `pb_corr` (two's complement, positive means output above reference) is added to the raw duty. The sum saturates to 0..1023 before the floor and ceiling are applied. With `mode_sec`=0, `pb_corr` has no effect.
- R9: The handover transition: in SOFT_RAMP with `ss_code` ≥ 742 (2.9 V) at an edge, the next state is STEADY_COMP, and `ss_done` reads 1 from that edge until the kill transition.
- R10: In STEADY_COMP every `hc_tick` edge loads 1023 − `pri_duty`. `pb_corr`, `mode_sec` and `ss_code` have no effect, and the state holds even if `ss_code` falls.
- R11: If the handover and an `hc_tick` happen at the same edge, that edge already loads 1023 − `pri_duty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low is the shutdown condition (undervoltage, enable off, overvoltage) |
| mode_sec | input | 1 | 1 = secondary-side control, pre-bias correction active |
| hc_tick | input | 1 | Half-cycle boundary strobe; duty is latched on it |
| ss_code | input | LW (10) | Soft-start level code, 256 codes per volt |
| comp_code | input | LW (10) | Compensation level code, same scale |
| pri_duty | input | DW (10) | Primary duty, fraction of a half-period |
| pb_corr | input | PW (8) | Signed pre-bias correction, in duty codes |
| sr_duty | output | DW (10) | SR duty command |
| sr_on | output | 1 | SR outputs active (state is not IDLE_OFF) |
| ss_done | output | 1 | Soft start complete (state is STEADY_COMP) |

## Verification
Directed points test the soft-start law at values that separate its parts. A zero compensation code shows the floor. A mid code shows the linear ramp scaling. A code above the peak shows saturation. A large primary duty shows that the ceiling wins over the floor. Correction terms of both signs are applied in both modes. This tells whether the term is gated by mode and saturated before the floor. Soft-start codes of 741 and 742, the second combined with a tick, pin down the handover edge and which value the handover tick loads. Seeded random stimulus then ramps the soft-start code at varying speed and toggles ticks, mode and enable. A bench model tracks the states, so ordering mistakes among kill, arm and handover show up.

// File: rtl/sr_duty_pkg.sv
package sr_duty_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_SOFT   = 2'd1,
        ST_STEADY = 2'd2
    } sr_state_e;
endpackage

// File: rtl/sr_ss_law.sv
module sr_ss_law #(
    parameter int DW        = 10,
    parameter int LW        = 10,
    parameter int PW        = 8,
    parameter int RAMP_PEAK = 768
) (
    input  logic [LW-1:0]        comp_code,
    input  logic [DW-1:0]        pri_duty,
    input  logic signed [PW-1:0] pb_corr,
    input  logic                 mode_sec,
    output logic [DW-1:0]        soft_duty
);
    localparam int MW = LW + DW + 1;
    localparam logic [DW-1:0] MAXD = '1;
    localparam logic [DW-1:0] HALF = DW'(1) << (DW - 1);
    localparam logic [LW-1:0] PEAK = LW'(RAMP_PEAK);

    logic [LW-1:0]        comp_c;
    logic [MW-1:0]        prod;
    logic [MW-1:0]        quot;
    logic [DW-1:0]        raw_sat;
    logic signed [DW+1:0] raw_s;
    logic signed [DW+1:0] pb_s;
    logic signed [DW+1:0] adj;
    logic [DW-1:0]        adj_sat;
    logic [DW-1:0]        floored;
    logic [DW-1:0]        ceil_d;

    // ramp comparison expressed as compensation / ramp peak, clipped at the peak
    always_comb begin
        comp_c = (comp_code > PEAK) ? PEAK : comp_code;
        prod   = MW'(comp_c) << DW;
        quot   = prod / MW'(RAMP_PEAK);
        raw_sat = (quot > MW'(MAXD)) ? MAXD : quot[DW-1:0];
    end

    // fast pre-bias correction, active only for secondary-side control
    always_comb begin
        raw_s = $signed({2'b00, raw_sat});
        pb_s  = mode_sec ? $signed({{(DW + 2 - PW){pb_corr[PW-1]}}, pb_corr}) : '0;
        adj   = raw_s + pb_s;
        if (adj < 0)
            adj_sat = '0;
        else if (adj > $signed({2'b00, MAXD}))
            adj_sat = MAXD;
        else
            adj_sat = adj[DW-1:0];
    end

    // half-period floor, then complement-of-primary ceiling (ceiling wins)
    always_comb begin
        ceil_d    = ~pri_duty;
        floored   = (adj_sat < HALF) ? HALF : adj_sat;
        soft_duty = (floored > ceil_d) ? ceil_d : floored;
    end
endmodule

// File: rtl/sr_seq_fsm.sv
module sr_seq_fsm
    import sr_duty_pkg::*;
#(
    parameter int LW          = 10,
    parameter int SS_DONE_LVL = 742
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [LW-1:0] ss_code,
    output sr_state_e     state,
    output sr_state_e     state_n,
    output logic          done
);
    localparam logic [LW-1:0] TH = LW'(SS_DONE_LVL);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_n;
    end

    // transitions: arm, handover, kill
    always_comb begin
        state_n = state;
        unique case (state)
            ST_OFF:    if (en) state_n = ST_SOFT;
            ST_SOFT: begin
                if (!en)               state_n = ST_OFF;
                else if (ss_code >= TH) state_n = ST_STEADY;
            end
            ST_STEADY: if (!en) state_n = ST_OFF;
            default:   state_n = ST_OFF;
        endcase
    end

    // registered completion flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done <= 1'b0;
        else        done <= (state_n == ST_STEADY);
    end
endmodule

// File: rtl/sr_duty_ctrl.sv
module sr_duty_ctrl
    import sr_duty_pkg::*;
#(
    parameter int DW          = 10,
    parameter int LW          = 10,
    parameter int PW          = 8,
    parameter int RAMP_PEAK   = 768,
    parameter int SS_DONE_LVL = 742
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 mode_sec,
    input  logic                 hc_tick,
    input  logic [LW-1:0]        ss_code,
    input  logic [LW-1:0]        comp_code,
    input  logic [DW-1:0]        pri_duty,
    input  logic signed [PW-1:0] pb_corr,
    output logic [DW-1:0]        sr_duty,
    output logic                 sr_on,
    output logic                 ss_done
);
    sr_state_e     state;
    sr_state_e     state_n;
    logic [DW-1:0] soft_duty;

    sr_seq_fsm #(.LW(LW), .SS_DONE_LVL(SS_DONE_LVL)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .ss_code (ss_code),
        .state   (state),
        .state_n (state_n),
        .done    (ss_done)
    );

    sr_ss_law #(.DW(DW), .LW(LW), .PW(PW), .RAMP_PEAK(RAMP_PEAK)) u_law (
        .comp_code (comp_code),
        .pri_duty  (pri_duty),
        .pb_corr   (pb_corr),
        .mode_sec  (mode_sec),
        .soft_duty (soft_duty)
    );

    // duty register: cleared on kill, reloaded only on half-cycle boundaries
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sr_duty <= '0;
        else if (state_n == ST_OFF)
            sr_duty <= '0;
        else if (hc_tick)
            sr_duty <= (state_n == ST_STEADY) ? ~pri_duty : soft_duty;
    end

    always_comb sr_on = (state != ST_OFF);
endmodule

// File: rtl/sr_duty_ctrl_chk.sv
module sr_duty_ctrl_chk #(
    parameter int DW          = 10,
    parameter int LW          = 10,
    parameter int PW          = 8,
    parameter int RAMP_PEAK   = 768,
    parameter int SS_DONE_LVL = 742
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 en,
    input logic                 mode_sec,
    input logic                 hc_tick,
    input logic [LW-1:0]        ss_code,
    input logic [LW-1:0]        comp_code,
    input logic [DW-1:0]        pri_duty,
    input logic signed [PW-1:0] pb_corr,
    input logic [DW-1:0]        sr_duty,
    input logic                 sr_on,
    input logic                 ss_done
);
    localparam logic [DW-1:0] HALF = DW'(1) << (DW - 1);
    localparam logic [LW-1:0] TH   = LW'(SS_DONE_LVL);

    assert_kill_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (sr_duty == '0 && !sr_on && !ss_done));

    assert_hold_between_ticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !hc_tick) |=> $stable(sr_duty));

    assert_ceiling_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && hc_tick) |=> (sr_duty <= ~$past(pri_duty)));

    assert_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && hc_tick && (~pri_duty >= HALF)) |=> (sr_duty >= HALF));

    assert_done_threshold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_done) |-> ($past(ss_code) >= TH));

    // R10 and R11: steady or handing-over ticks load the primary complement
    assert_steady_complement_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && hc_tick && (ss_done || (sr_on && ss_code >= TH)))
            |=> (sr_duty == ~$past(pri_duty)));
endmodule

bind sr_duty_ctrl sr_duty_ctrl_chk #(
    .DW(DW), .LW(LW), .PW(PW), .RAMP_PEAK(RAMP_PEAK), .SS_DONE_LVL(SS_DONE_LVL)
) u_chk (.*);

// File: tb/sr_duty_ctrl_tb.sv
module sr_duty_ctrl_tb;
    logic              clk = 1'b0;
    logic              rst_n;
    logic              en, mode_sec, hc_tick;
    logic [9:0]        ss_code, comp_code, pri_duty;
    logic signed [7:0] pb_corr;
    logic [9:0]        sr_duty;
    logic              sr_on, ss_done;

    int errors = 0;
    int checks = 0;
    int m_st   = 0;   // 0 idle, 1 soft, 2 steady
    int m_duty = 0;
    bit m_done = 0;

    always #5 clk = ~clk;

    sr_duty_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .mode_sec(mode_sec), .hc_tick(hc_tick),
        .ss_code(ss_code), .comp_code(comp_code), .pri_duty(pri_duty),
        .pb_corr(pb_corr), .sr_duty(sr_duty), .sr_on(sr_on), .ss_done(ss_done)
    );

    function automatic int soft_law(int c, int p, int b, bit s);
        int r;
        if (c > 768) c = 768;
        r = (c * 1024) / 768;
        if (r > 1023) r = 1023;
        if (s) r = r + b;
        if (r < 0) r = 0;
        if (r > 1023) r = 1023;
        if (r < 512) r = 512;
        if (r > 1023 - p) r = 1023 - p;
        return r;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input bit e, input bit t, input int ss, input int c,
                        input int p, input int b, input bit s);
        int    nst;
        string tag;
        en = e; hc_tick = t; ss_code = 10'(ss); comp_code = 10'(c);
        pri_duty = 10'(p); pb_corr = 8'(b); mode_sec = s;
        nst = m_st;
        if (!e) nst = 0;
        else if (m_st == 0) nst = 1;
        else if (m_st == 1 && ss >= 742) nst = 2;
        if (!e) tag = "R2";
        else if (m_st == 0) tag = "R3";
        else if (!t) tag = "R4";
        else if (nst == 2) tag = (m_st == 1) ? "R11" : "R10";
        else if (s) tag = "R8";
        else tag = "R5";
        @(posedge clk);
        if (nst == 0) m_duty = 0;
        else if (t) m_duty = (nst == 2) ? (1023 - p) : soft_law(c, p, b, s);
        m_done = (nst == 2);
        m_st = nst;
        @(negedge clk);
        check(tag, int'(sr_duty), m_duty);
        check("R9", int'(ss_done), int'(m_done));
        check("R3", int'(sr_on), int'(m_st != 0));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int ss;
        void'($urandom(32'd1234));
        rst_n = 1'b0; en = 0; mode_sec = 0; hc_tick = 0;
        ss_code = 0; comp_code = 0; pri_duty = 0; pb_corr = 0;
        repeat (3) @(negedge clk);
        check("R1", int'(sr_duty), 0);
        check("R1", int'(sr_on), 0);
        check("R1", int'(ss_done), 0);
        rst_n = 1'b1;

        step(1, 0, 100, 0, 100, 0, 0);   check("R3", int'(sr_on), 1);
        check("R4", int'(sr_duty), 0);
        step(1, 1, 100, 0, 100, 0, 0);   check("R6", int'(sr_duty), 512);
        step(1, 1, 110, 600, 100, 0, 0); check("R5", int'(sr_duty), 800);
        step(1, 1, 120, 900, 100, 0, 0); check("R7", int'(sr_duty), 923);
        step(1, 1, 130, 600, 700, 0, 0); check("R7", int'(sr_duty), 323);
        step(1, 1, 140, 600, 0, 100, 0); check("R8", int'(sr_duty), 800);
        step(1, 1, 150, 600, 0, 100, 1); check("R8", int'(sr_duty), 900);
        step(1, 1, 160, 600, 0, -128, 1); check("R8", int'(sr_duty), 672);
        step(1, 1, 170, 0, 0, -128, 1);  check("R8", int'(sr_duty), 512);
        step(1, 1, 180, 768, 0, 127, 1); check("R8", int'(sr_duty), 1023);
        step(1, 0, 190, 0, 900, 0, 0);   check("R4", int'(sr_duty), 1023);
        step(1, 1, 741, 600, 0, 0, 0);   check("R9", int'(ss_done), 0);
        step(1, 1, 742, 600, 200, 50, 1); check("R11", int'(sr_duty), 823);
        check("R9", int'(ss_done), 1);
        step(1, 1, 0, 0, 300, 50, 1);    check("R10", int'(sr_duty), 723);
        check("R10", int'(ss_done), 1);
        step(0, 1, 0, 0, 300, 0, 0);     check("R2", int'(sr_duty), 0);
        check("R2", int'(ss_done), 0);

        ss = 0;
        for (int i = 0; i < 4000; i++) begin
            bit e;
            e = ($urandom_range(99) >= 3);
            if (!e) ss = 0;
            else if (ss < 1023) ss = ss + int'($urandom_range(2));
            if (ss > 1023) ss = 1023;
            step(e, ($urandom_range(3) == 0), ss, int'($urandom_range(1023)),
                 int'($urandom_range(1023)), int'($urandom_range(255)) - 128,
                 bit'($urandom_range(1)));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule